// File: doc/BRIEF.md
# Conversion Result Word Formatter

This block sits between the control strobes of a multiplexed sampling converter and its parallel data bus. It tracks the six configuration inputs (pair mode, three-bit channel address, polarity, gain). It freezes the configuration that is in force when a conversion is started and drives it to the analog front end. When the converter reports a finished 12-bit offset-binary code, the block builds a 16-bit result word. The upper four bits of that word name the input that was actually sampled. The lower twelve bits hold the code, in straight binary or in two's complement as chosen by the polarity captured at the start.

All strobes are active low and are resampled on the system clock. Edges are found on the registered copies. An external address generator, such as a scan counter or a sequencer, can take over the pair bit and the address through a select input. The read strobe gates the bus. A disabled bus is shown as a low enable flag with all data bits forced to zero.

Top module: `wfmt_top`

## Requirements
- R1: The result word places the pair bit at bit 15, the channel address at bits 14:12 and the 12-bit data at bits 11:0.
- R2: The tag in bits 15:12 is the pair bit and address in force at the conversion-start falling edge, even if the pins change before the result arrives.
- R3: With polarity 0 captured at start, the data field equals the converter code unchanged (straight binary).
- R4: With polarity 1 captured at start, the data field is the two's complement value of code minus 2048: code 0x800 gives 0x000, 0xFFF gives 0x7FF, 0x000 gives 0x800.
- R5: One clock after rd_n is sampled low, bus_oe is 1 and bus_data shows the result word. One clock after rd_n is sampled high, bus_oe is 0 and bus_data is all zero.
- R6: mux_cfg is packed as {pair, addr[2:0], bipolar, gain}. While wr_n is low and no conversion is running, mux_cfg follows the pins one clock later. After wr_n rises, mux_cfg keeps the last value seen while it was low, and later pin changes have no effect.
- R7: From the clock after a cnv_n falling edge until the done pulse, mux_cfg holds the configuration sampled at that edge, even while wr_n stays low and the pins change.
- R8: With use_gen high, the pair bit and address in both mux_cfg and the result tag come from gen_tag, and the pin values for those fields are ignored.
- R9: The result word changes only on a conv_done pulse during a running conversion. A conv_done pulse while idle leaves the word unchanged.
- R10: After reset, bus_oe is 0, mux_cfg is 0 and the stored result word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_n | input | 1 | Configuration write strobe, low passes, rising edge latches |
| cnv_n | input | 1 | Convert-start strobe, falling edge starts a conversion |
| rd_n | input | 1 | Read strobe, low enables the bus |
| cfg_pair | input | 1 | Pair (differential) select pin |
| cfg_addr | input | 3 | Channel address pins |
| cfg_bipolar | input | 1 | Polarity select pin, 1 = bipolar |
| cfg_gain | input | 1 | Gain select pin, passed through |
| use_gen | input | 1 | Take pair bit and address from gen_tag |
| gen_tag | input | 4 | Generated {pair, addr} from a scan or sequence source |
| conv_code | input | 12 | Offset-binary code from the converter |
| conv_done | input | 1 | One-cycle pulse marking conv_code valid |
| mux_cfg | output | 6 | Applied configuration {pair, addr, bipolar, gain} |
| bus_oe | output | 1 | Bus driven flag |
| bus_data | output | 16 | Result word, zero when not driven |

## Verification
A conversion start and a change of the configuration pins can fall in the same window. The bench moves the pins, or releases the write strobe, between the start edge and the done pulse, both with the write strobe held low and with it already latched. It then judges the frozen mux_cfg and the result tag against the values present at the start. The second overlap is a read that stays enabled across a done pulse. Here the bus must switch to the new word exactly one clock after done is sampled, and a done pulse with no conversion pending must leave the word on the bus untouched.

// File: rtl/wfmt_pkg.sv
// Shared widths and the configuration record used by the result word formatter.
package wfmt_pkg;
    localparam int CODE_W = 12;                 // converter code width
    localparam int ADDR_W = 3;                  // channel address width
    localparam int TAG_W  = ADDR_W + 1;         // pair bit plus address
    localparam int CFG_W  = TAG_W + 2;          // tag plus polarity and gain
    localparam int WORD_W = TAG_W + CODE_W;     // result word width

    typedef struct packed {
        logic              pair;
        logic [ADDR_W-1:0] addr;
        logic              bipolar;
        logic              gain;
    } cfg_t;
endpackage

// File: rtl/wfmt_strobe_sync.sv
// Registers a set of active-low strobes and keeps the previous sample, so
// callers can detect edges. Assumes strobes are synchronous or slow enough
// for single-stage sampling; idle level after reset is high.
module wfmt_strobe_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_n,
    output logic [N-1:0] now_q,
    output logic [N-1:0] prev_q
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_bit
            // Two-deep history of one strobe, idle high
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    now_q[i]  <= 1'b1;
                    prev_q[i] <= 1'b1;
                end else begin
                    now_q[i]  <= raw_n[i];
                    prev_q[i] <= now_q[i];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/wfmt_cfg_capture.sv
// Holds the configuration: transparent while the write strobe is low,
// latched when it rises, frozen from conversion start to done.
// Assumes inputs are already registered; start is a one-cycle event.
module wfmt_cfg_capture
    import wfmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_q,
    input  logic             start,
    input  logic             done,
    input  cfg_t             pins_q,
    input  logic             use_gen_q,
    input  logic [TAG_W-1:0] gen_q,
    output logic             busy,
    output cfg_t             frozen,
    output cfg_t             cfg_out
);
    cfg_t hold;
    cfg_t base;
    cfg_t live;

    // Write latch: track pins while write is low and no conversion runs
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold <= '0;
        else if (!busy && !wr_q)
            hold <= pins_q;
    end

    // Pick pass-through or latched value, then apply generated address
    always_comb begin
        base = wr_q ? hold : pins_q;
        live = base;
        if (use_gen_q) begin
            live.pair = gen_q[TAG_W-1];
            live.addr = gen_q[ADDR_W-1:0];
        end
    end

    // Conversion window: snapshot at start, release at done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            frozen <= '0;
        end else if (!busy && start) begin
            busy   <= 1'b1;
            frozen <= live;
        end else if (busy && done) begin
            busy   <= 1'b0;
        end
    end

    // Applied configuration toward the analog front end
    always_comb cfg_out = busy ? frozen : live;
endmodule

// File: rtl/wfmt_result_fmt.sv
// Forms and stores the result word from the frozen tag and the converter
// code, and gates it onto the bus. Assumes code is offset binary.
module wfmt_result_fmt
    import wfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              done,
    input  cfg_t              frozen,
    input  logic [CODE_W-1:0] code,
    input  logic              rd_q,
    output logic              bus_oe,
    output logic [WORD_W-1:0] bus_data
);
    logic [WORD_W-1:0] word;
    logic [CODE_W-1:0] data;

    // Offset binary to two's complement is an MSB flip
    always_comb begin
        data = code;
        if (frozen.bipolar)
            data[CODE_W-1] = ~code[CODE_W-1];
    end

    // Result register: updated only when a running conversion finishes
    always_ff @(posedge clk) begin
        if (!rst_n)
            word <= '0;
        else if (busy && done)
            word <= {frozen.pair, frozen.addr, data};
    end

    // Bus gating from the registered read strobe
    always_comb begin
        bus_oe   = ~rd_q;
        bus_data = bus_oe ? word : '0;
    end
endmodule

// File: rtl/wfmt_top.sv
// Conversion result word formatter top: resamples strobes and pins,
// captures configuration, formats and presents the result word.
module wfmt_top
    import wfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              cnv_n,
    input  logic              rd_n,
    input  logic              cfg_pair,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_bipolar,
    input  logic              cfg_gain,
    input  logic              use_gen,
    input  logic [TAG_W-1:0]  gen_tag,
    input  logic [CODE_W-1:0] conv_code,
    input  logic              conv_done,
    output logic [CFG_W-1:0]  mux_cfg,
    output logic              bus_oe,
    output logic [WORD_W-1:0] bus_data
);
    localparam int STRB_N = 3;

    logic [STRB_N-1:0] strb_q, strb_prev;
    cfg_t              pins_q;
    logic              use_gen_q;
    logic [TAG_W-1:0]  gen_q;
    logic              start;
    logic              busy;
    cfg_t              frozen;
    cfg_t              cfg_out;

    wfmt_strobe_sync #(.N(STRB_N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_n  ({rd_n, cnv_n, wr_n}),
        .now_q  (strb_q),
        .prev_q (strb_prev)
    );

    // Pin register aligned with the strobe samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_q    <= '0;
            use_gen_q <= 1'b0;
            gen_q     <= '0;
        end else begin
            pins_q    <= '{pair: cfg_pair, addr: cfg_addr,
                           bipolar: cfg_bipolar, gain: cfg_gain};
            use_gen_q <= use_gen;
            gen_q     <= gen_tag;
        end
    end

    // Convert-start falling edge
    always_comb start = strb_prev[1] & ~strb_q[1];

    wfmt_cfg_capture u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_q      (strb_q[0]),
        .start     (start),
        .done      (conv_done),
        .pins_q    (pins_q),
        .use_gen_q (use_gen_q),
        .gen_q     (gen_q),
        .busy      (busy),
        .frozen    (frozen),
        .cfg_out   (cfg_out)
    );

    wfmt_result_fmt u_fmt (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .done     (conv_done),
        .frozen   (frozen),
        .code     (conv_code),
        .rd_q     (strb_q[2]),
        .bus_oe   (bus_oe),
        .bus_data (bus_data)
    );

    always_comb mux_cfg = cfg_out;
endmodule

// File: rtl/wfmt_chk.sv
// Temporal checks on the formatter, attached by bind.
module wfmt_chk
    import wfmt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_n,
    input logic              conv_done,
    input logic              busy,
    input logic [CFG_W-1:0]  mux_cfg,
    input logic              bus_oe,
    input logic [WORD_W-1:0] bus_data
);
    // R5
    rd_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |=> bus_oe);
    // R5
    rd_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |=> !bus_oe);
    // R5
    hiz_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_data == '0));
    // R9
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && $past(bus_oe) && !$past(conv_done && busy)) |-> $stable(bus_data));
    // R7
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mux_cfg));
endmodule

bind wfmt_top wfmt_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_n      (rd_n),
    .conv_done (conv_done),
    .busy      (busy),
    .mux_cfg   (mux_cfg),
    .bus_oe    (bus_oe),
    .bus_data  (bus_data)
);

// File: tb/wfmt_top_test.sv
module wfmt_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_n = 1'b1, cnv_n = 1'b1, rd_n = 1'b1;
    logic        cfg_pair = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic        cfg_bipolar = 1'b0, cfg_gain = 1'b0;
    logic        use_gen = 1'b0;
    logic [3:0]  gen_tag = '0;
    logic [11:0] conv_code = '0;
    logic        conv_done = 1'b0;
    logic [5:0]  mux_cfg;
    logic        bus_oe;
    logic [15:0] bus_data;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;

    always #5ns clk = ~clk;

    wfmt_top uut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .cnv_n(cnv_n), .rd_n(rd_n),
        .cfg_pair(cfg_pair), .cfg_addr(cfg_addr), .cfg_bipolar(cfg_bipolar),
        .cfg_gain(cfg_gain), .use_gen(use_gen), .gen_tag(gen_tag),
        .conv_code(conv_code), .conv_done(conv_done),
        .mux_cfg(mux_cfg), .bus_oe(bus_oe), .bus_data(bus_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected data field: straight code, or signed value of code-2048
    function automatic logic [11:0] exp_data(input logic bip, input logic [11:0] code);
        int v;
        if (!bip) return code;
        v = int'(code) - 2048;
        return 12'(v);
    endfunction

    task automatic set_pins(input logic [3:0] tag, input logic bip, input logic gain);
        {cfg_pair, cfg_addr} = tag;
        cfg_bipolar = bip;
        cfg_gain = gain;
    endtask

    // Latch config, scramble pins, start, finish; check frozen cfg and word
    task automatic run_conv(input logic [3:0] tag, input logic bip, input logic gain,
                            input logic [11:0] code, input logic [3:0] exp_tag);
        @(negedge clk); set_pins(tag, bip, gain); wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); set_pins(~tag, ~bip, ~gain); cnv_n = 1'b0;
        @(negedge clk); cnv_n = 1'b1;
        @(negedge clk);
        check("R2 frozen mux_cfg", 32'(mux_cfg), 32'({exp_tag, bip, gain}));
        conv_code = code; conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0; conv_code = ~code;
        check("R1/R2 tag field", 32'(bus_data[15:12]), 32'(exp_tag));
        if (bip) check("R4 two's complement data", 32'(bus_data[11:0]), 32'(exp_data(1'b1, code)));
        else     check("R3 straight binary data", 32'(bus_data[11:0]), 32'(exp_data(1'b0, code)));
    endtask

    initial begin : watchdog
        #2ms;
        if (!ended) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [11:0] codes [5];
        logic [15:0] last;
        codes[0] = 12'h000; codes[1] = 12'h7FF; codes[2] = 12'h800;
        codes[3] = 12'hFFF; codes[4] = 12'h5A3;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 bus_oe after reset", 32'(bus_oe), 0);
        check("R10 mux_cfg after reset", 32'(mux_cfg), 0);
        rd_n = 1'b0;
        @(negedge clk);
        check("R10 stored word after reset", 32'(bus_data), 0);
        check("R5 bus_oe after rd low", 32'(bus_oe), 1);

        // Sweep: every tag, both polarities, boundary codes (R1 R2 R3 R4)
        for (int t = 0; t < 16; t++)
            for (int b = 0; b < 2; b++)
                for (int c = 0; c < 5; c++)
                    run_conv(4'(t), 1'(b), 1'(t), codes[c], 4'(t));

        // R8 generated address overrides pins
        use_gen = 1'b1;
        for (int g = 0; g < 16; g++) begin
            gen_tag = 4'(g);
            run_conv(4'(15 - g), 1'b1, 1'b0, 12'h123, 4'(g));
        end
        use_gen = 1'b0;
        @(negedge clk);

        // R6 pass-through while write low, then latched
        set_pins(4'hA, 1'b1, 1'b0); wr_n = 1'b0;
        @(negedge clk);
        check("R6 pass-through", 32'(mux_cfg), 32'({4'hA, 1'b1, 1'b0}));
        set_pins(4'h3, 1'b0, 1'b1);
        @(negedge clk);
        check("R6 pass-through follows", 32'(mux_cfg), 32'({4'h3, 1'b0, 1'b1}));
        wr_n = 1'b1;
        @(negedge clk); set_pins(4'hC, 1'b1, 1'b1);
        @(negedge clk); @(negedge clk);
        check("R6 latched after write rise", 32'(mux_cfg), 32'({4'h3, 1'b0, 1'b1}));

        // R7 write held low, start freezes, pins move during conversion
        set_pins(4'h6, 1'b1, 1'b0); wr_n = 1'b0;
        @(negedge clk); cnv_n = 1'b0;
        @(negedge clk); cnv_n = 1'b1;
        @(negedge clk); set_pins(4'h9, 1'b0, 1'b1);
        @(negedge clk); @(negedge clk);
        check("R7 frozen while write low", 32'(mux_cfg), 32'({4'h6, 1'b1, 1'b0}));
        conv_code = 12'hFFF; conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
        check("R7 word tag from start", 32'(bus_data), 32'({4'h6, 12'h7FF}));
        check("R7 released after done", 32'(mux_cfg), 32'({4'h9, 1'b0, 1'b1}));
        wr_n = 1'b1;

        // R9 done while idle is ignored
        last = bus_data;
        @(negedge clk); conv_code = 12'h001; conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
        @(negedge clk);
        check("R9 idle done ignored", 32'(bus_data), 32'(last));

        // R5 read strobe gating
        rd_n = 1'b1;
        @(negedge clk);
        check("R5 bus_oe off", 32'(bus_oe), 0);
        check("R5 data zero when off", 32'(bus_data), 0);
        rd_n = 1'b0;
        @(negedge clk);
        check("R5 bus_oe on", 32'(bus_oe), 1);
        check("R5 word back on bus", 32'(bus_data), 32'(last));

        ended = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule